// File: doc/BRIEF.md
# Serial Transmitter with Selectable Parity

This block turns a data word into an asynchronous serial frame on a single output line. A byte-wide control register sets the character length to 7, 8 or 9 data bits. It also turns the parity bit on or off and picks its kind: odd, even, forced one or forced zero. One control bit has two jobs. In 7-bit and 8-bit modes it is the low parity-select bit. In 9-bit mode it is the ninth data bit that goes on the line.

Software reaches the block through one write port. The select input steers each write either to the control register or to a one-word transmit holding buffer. A read-only flag shows when the buffer can take another word. Bit timing comes from an external baud-enable pulse: each bit stays on the line for a fixed number of those pulses. Control settings and data are captured when a word moves from the buffer into the shifter. A control write made while a frame is on the line therefore affects only later frames.

Top module: `sertx_core`

## Requirements
- R1: After a synchronous active-low reset, the line is 1, the buffer-empty flag is 1 and the status output reads 8'h01.
- R2: A write with select 0 stores write data bits 7..3 into status bits 7..3. Bit 7 is parity enable, bit 6 is parity select high, bit 5 is the shared bit, and bits 4..3 are the length code. Status bits 2..1 always read 0. Status bit 0 mirrors the buffer-empty flag, and writes cannot change it.
- R3: The length code {bit4,bit3} selects the character length: 00 = 8 data bits, 01 = 7 data bits (bits 6..0 of the word), 10 = 9 data bits, 11 = 8 data bits.
- R4: A frame is a 0 start bit, the data bits least significant first, an optional extra bit, and a 1 stop bit. The line rests at 1 between frames.
- R5: Every frame bit stays on the line for exactly TICKS_PER_BIT baud-enable pulses. While a frame is in flight, the line changes only in the cycle after a pulse.
- R6: In 7-bit or 8-bit mode with parity enabled, the extra bit is set by {bit6,bit5}: 00 = odd (the total count of ones in data plus parity is odd), 01 = even, 10 = always 1, 11 = always 0.
- R7: In 7-bit or 8-bit mode with parity disabled, no extra bit is sent.
- R8: In 9-bit mode, bit 5 is sent as the ninth data bit after the eight data bits, and the parity-enable bit has no effect.
- R9: An accepted write with select 1 clears the buffer-empty flag on the next edge. The flag sets again on the edge at which the word moves into the idle shifter.
- R10: A write with select 1 while the buffer-empty flag is 0 is ignored. The word already held is the one that is sent.
- R11: Data and control settings are taken when a word is loaded into the shifter. A control write during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 = control register, 1 = transmit buffer |
| wr_data | input | 8 | Write data |
| baud_tick | input | 1 | Baud-enable pulse, one clock wide |
| tx_line | output | 1 | Serial output, idles at 1 |
| ctrl_status | output | 8 | Control bits 7..3, zeros in 2..1, buffer-empty in bit 0 |
| buf_empty | output | 1 | Transmit buffer can accept a word |

## Verification
The hardest case to reach is a word waiting in the buffer while the shifter is busy, with a control write landing in the same window. That case tests three things together: the ignored second buffer write, the capture of settings at load time, and the back-to-back reload after the stop bit. The stimulus writes one word and a second word on consecutive cycles. It writes a third word as soon as the flag rises, then rewrites the control register while that frame is on the line. Baud pulses arrive at random spacing, so a bit-length error cannot hide behind a regular pulse pattern.

// File: rtl/sertx_pkg.sv
// Package: shared encodings and the control-bit structure for the serial transmitter.
// Assumes the control fields occupy write-data bits 7..3 in the order of cfg_t.
package sertx_pkg;

    // Length code carried in control bits 4..3.
    typedef enum logic [1:0] {
        LEN_8   = 2'b00,
        LEN_7   = 2'b01,
        LEN_9   = 2'b10,
        LEN_8B  = 2'b11
    } char_len_e;

    // Parity kind carried in control bits 6..5 (7/8-bit modes only).
    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_kind_e;

    // Stored control bits, most significant first.
    typedef struct packed {
        logic      par_en;
        logic      psel_hi;
        logic      shared_b;
        char_len_e len;
    } cfg_t;

endpackage

// File: rtl/sertx_cfg_reg.sv
// Module: control register holding parity and length settings.
// Assumes wr_sel = 0 addresses this register; bits 2..0 of the write are dropped.
module sertx_cfg_reg
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output cfg_t       cfg_o
);

    cfg_t cfg_q;

    // Capture the writable control bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en && !wr_sel) begin
            cfg_q <= cfg_t'(wr_data[7:3]);
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/sertx_holdbuf.sv
// Module: single-word transmit holding buffer with a full flag.
// Assumes take_i is asserted only while full_o is 1; writes while full are dropped.
module sertx_holdbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    logic              full_q;
    logic [DATA_W-1:0] data_q;

    // Accept a word when empty, release it when the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take_i) begin
            full_q <= 1'b0;
        end else if (wr_en && wr_sel && !full_q) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;

endmodule

// File: rtl/sertx_framer.sv
// Module: combinational frame builder.
// Produces start, data (LSB first), optional parity or ninth bit, and stop, plus the frame length.
// Assumes FRAME_MAX = DATA_W + 3 so the longest frame fits.
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int FRAME_MAX = DATA_W + 3,
    parameter int IDX_W     = $clog2(FRAME_MAX + 1)
) (
    input  logic [DATA_W-1:0]    data_i,
    input  cfg_t                 cfg_i,
    output logic [FRAME_MAX-1:0] frame_o,
    output logic [IDX_W-1:0]     len_o
);

    int                ndata;
    logic              nine_mode;
    logic              extra_en;
    logic              extra_val;
    logic              xr;
    logic [DATA_W-1:0] used;

    // Decide which data bits count and what the extra bit is.
    always_comb begin
        nine_mode = (cfg_i.len == LEN_9);
        ndata     = (cfg_i.len == LEN_7) ? DATA_W - 1 : DATA_W;
        used      = data_i;
        if (cfg_i.len == LEN_7) begin
            used[DATA_W-1] = 1'b0;
        end
        xr = ^used;
        if (nine_mode) begin
            extra_en  = 1'b1;
            extra_val = cfg_i.shared_b;
        end else begin
            extra_en = cfg_i.par_en;
            case (par_kind_e'({cfg_i.psel_hi, cfg_i.shared_b}))
                PAR_ODD:   extra_val = ~xr;
                PAR_EVEN:  extra_val = xr;
                PAR_MARK:  extra_val = 1'b1;
                default:   extra_val = 1'b0;
            endcase
        end
    end

    // Lay the bits out in transmission order; unused upper positions stay 1.
    always_comb begin
        frame_o    = '1;
        frame_o[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < ndata) begin
                frame_o[1+i] = data_i[i];
            end
        end
        for (int j = 1; j < FRAME_MAX; j++) begin
            if (extra_en && (j == ndata + 1)) begin
                frame_o[j] = extra_val;
            end
        end
        len_o = IDX_W'(ndata + 2 + (extra_en ? 1 : 0));
    end

endmodule

// File: rtl/sertx_shifter.sv
// Module: frame shifter and bit timer.
// Loads a frame when idle and a word is waiting, then holds each bit for TICKS_PER_BIT
// baud pulses. Assumes baud_tick is one clock wide.
module sertx_shifter #(
    parameter int FRAME_MAX     = 11,
    parameter int IDX_W         = $clog2(FRAME_MAX + 1),
    parameter int TICKS_PER_BIT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 full_i,
    input  logic [FRAME_MAX-1:0] frame_i,
    input  logic [IDX_W-1:0]     len_i,
    output logic                 take_o,
    output logic                 busy_o,
    output logic                 line_o
);

    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

    logic                 busy_q;
    logic                 line_q;
    logic [CNT_W-1:0]     tick_cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [IDX_W-1:0]     len_q;
    logic [FRAME_MAX-1:0] shreg_q;
    logic                 bit_done;
    logic                 last_bit;

    assign take_o   = !busy_q && full_i;
    assign bit_done = baud_tick && (tick_cnt_q == CNT_W'(TICKS_PER_BIT - 1));
    assign last_bit = (idx_q == len_q - IDX_W'(1));

    // Load, time and shift the frame; drop back to idle after the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            line_q     <= 1'b1;
            tick_cnt_q <= '0;
            idx_q      <= '0;
            len_q      <= '0;
            shreg_q    <= '1;
        end else if (take_o) begin
            busy_q     <= 1'b1;
            line_q     <= frame_i[0];
            tick_cnt_q <= '0;
            idx_q      <= '0;
            len_q      <= len_i;
            shreg_q    <= frame_i;
        end else if (busy_q && baud_tick) begin
            if (bit_done) begin
                tick_cnt_q <= '0;
                if (last_bit) begin
                    busy_q <= 1'b0;
                    line_q <= 1'b1;
                end else begin
                    idx_q   <= idx_q + IDX_W'(1);
                    line_q  <= shreg_q[1];
                    shreg_q <= {1'b1, shreg_q[FRAME_MAX-1:1]};
                end
            end else begin
                tick_cnt_q <= tick_cnt_q + CNT_W'(1);
            end
        end
    end

    assign busy_o = busy_q;
    assign line_o = line_q;

endmodule

// File: rtl/sertx_core.sv
// Module: serial transmitter top. Ties the control register, holding buffer,
// frame builder and shifter together and forms the status byte.
// Assumes an 8-bit write port; DATA_W must be 8 so the ninth bit comes from control.
module sertx_core #(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       baud_tick,
    output logic       tx_line,
    output logic [7:0] ctrl_status,
    output logic       buf_empty
);

    import sertx_pkg::*;

    localparam int FRAME_MAX = DATA_W + 3;
    localparam int IDX_W     = $clog2(FRAME_MAX + 1);

    cfg_t                 cfg_w;
    logic                 full_w;
    logic                 take_w;
    logic                 busy_w;
    logic [DATA_W-1:0]    hold_w;
    logic [FRAME_MAX-1:0] frame_w;
    logic [IDX_W-1:0]     len_w;

    sertx_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg_o   (cfg_w)
    );

    sertx_holdbuf #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data[DATA_W-1:0]),
        .take_i  (take_w),
        .full_o  (full_w),
        .data_o  (hold_w)
    );

    sertx_framer #(
        .DATA_W    (DATA_W),
        .FRAME_MAX (FRAME_MAX),
        .IDX_W     (IDX_W)
    ) u_framer (
        .data_i  (hold_w),
        .cfg_i   (cfg_w),
        .frame_o (frame_w),
        .len_o   (len_w)
    );

    sertx_shifter #(
        .FRAME_MAX     (FRAME_MAX),
        .IDX_W         (IDX_W),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .full_i    (full_w),
        .frame_i   (frame_w),
        .len_i     (len_w),
        .take_o    (take_w),
        .busy_o    (busy_w),
        .line_o    (tx_line)
    );

    assign buf_empty   = !full_w;
    assign ctrl_status = {cfg_w, 2'b00, !full_w};

endmodule

// File: rtl/sertx_core_chk.sv
// Module: property checker for sertx_core, attached by bind below.
// Assumes reset is held for at least one clock before release.
module sertx_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [7:0]        wr_data,
    input logic              baud_tick,
    input logic              tx_line,
    input logic [7:0]        ctrl_status,
    input logic              buf_empty,
    input logic              busy,
    input logic [DATA_W-1:0] hold
);

    // R2: a control write shows up in the status bits on the next cycle.
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (ctrl_status[7:3] == $past(wr_data[7:3])));

    // R4: the line rests high while no frame is in flight.
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    // R4: a frame opens with a low start bit.
    assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_line);

    // R5: mid-frame, the line moves only after a baud pulse.
    assert_line_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(baud_tick)) |-> $stable(tx_line));

    // R9: the empty flag drops only because of a buffer write.
    assert_empty_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_empty) |-> $past(wr_en && wr_sel));

    // R10: a buffer write while full leaves the held word alone.
    assert_full_write_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_empty && wr_en && wr_sel) |=> $stable(hold));

endmodule

bind sertx_core sertx_core_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .baud_tick   (baud_tick),
    .tx_line     (tx_line),
    .ctrl_status (ctrl_status),
    .buf_empty   (buf_empty),
    .busy        (busy_w),
    .hold        (hold_w)
);

// File: tb/sertx_core_tb_top.sv
// Bench: behavioural reference model (bit queue plus counters) compared on every clock.
module sertx_core_tb_top;

    localparam int TPB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic       tx_line;
    logic [7:0] ctrl_status;
    logic       buf_empty;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // Reference model state.
    bit       m_full, m_busy, m_line;
    bit [4:0] m_ctrl;
    bit [7:0] m_buf;
    bit       m_q[$];
    int       m_tick;

    sertx_core #(.DATA_W(8), .TICKS_PER_BIT(TPB)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .baud_tick   (baud_tick),
        .tx_line     (tx_line),
        .ctrl_status (ctrl_status),
        .buf_empty   (buf_empty)
    );

    always #5 clk = ~clk;

    // Random baud pulses, driven away from the sampling edge.
    always @(negedge clk) baud_tick <= ($urandom_range(0, 2) == 0);

    // Build the expected bit sequence from the requirement text.
    function automatic void build_frame(bit [7:0] d, bit [4:0] c);
        int  nd;
        int  ones;
        bit  pen;
        bit [1:0] ps;
        bit [1:0] ln;
        pen = c[4]; ps = c[3:2]; ln = c[1:0];
        nd = (ln == 2'b01) ? 7 : 8;
        ones = 0;
        m_q.delete();
        m_q.push_back(1'b0);
        for (int i = 0; i < nd; i++) begin
            m_q.push_back(d[i]);
            ones += d[i];
        end
        if (ln == 2'b10) m_q.push_back(c[2]);
        else if (pen) begin
            case (ps)
                2'b00: m_q.push_back((ones % 2) == 0);
                2'b01: m_q.push_back((ones % 2) == 1);
                2'b10: m_q.push_back(1'b1);
                default: m_q.push_back(1'b0);
            endcase
        end
        m_q.push_back(1'b1);
    endfunction

    // Advance the model on each rising edge using the inputs held since the last falling edge.
    always @(posedge clk) begin
        bit old_full;
        if (!rst_n) begin
            m_full = 0; m_busy = 0; m_line = 1; m_ctrl = 0; m_buf = 0; m_tick = 0;
            m_q.delete();
        end else begin
            old_full = m_full;
            if (!m_busy && m_full) begin
                build_frame(m_buf, m_ctrl);
                m_busy = 1; m_tick = 0; m_line = m_q[0]; m_full = 0;
            end else if (m_busy && baud_tick) begin
                if (m_tick == TPB - 1) begin
                    m_tick = 0;
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) begin
                        m_busy = 0; m_line = 1;
                    end else m_line = m_q[0];
                end else m_tick++;
            end
            if (wr_en && !wr_sel) m_ctrl = wr_data[7:3];
            if (wr_en && wr_sel && !old_full) begin
                m_buf = wr_data; m_full = 1;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(cur_req, "tx_line", tx_line, m_line);
            check(cur_req, "buf_empty", buf_empty, !m_full);
            check(cur_req, "ctrl_status", ctrl_status, {m_ctrl, 2'b00, !m_full});
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        wait (cycles > 150000);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    task automatic wr(bit sel, bit [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (m_busy || m_full) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic send(string req, bit [7:0] c, bit [7:0] d);
        cur_req = req;
        wr(1'b0, c);
        wr(1'b1, d);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values seen at the ports while reset is still asserted.
        check("R1", "reset tx_line", tx_line, 1);
        check("R1", "reset buf_empty", buf_empty, 1);
        check("R1", "reset status", ctrl_status, 8'h01);
        rst_n = 1;
        repeat (2) @(negedge clk);

        send("R4", 8'h00, 8'hA5);              // 8 data bits, no parity
        send("R6", 8'h88, 8'h53);              // 7 bits, odd parity
        send("R6", 8'hA0, 8'h3C);              // 8 bits, even parity
        send("R6", 8'hC0, 8'h00);              // 8 bits, mark
        send("R6", 8'hE8, 8'h7F);              // 7 bits, space
        send("R6", 8'h80, 8'hFF);              // 8 bits, odd, all ones
        send("R7", 8'h08, 8'hD2);              // 7 bits, parity off
        send("R8", 8'hB0, 8'h96);              // 9 bits, ninth = 1, enable ignored
        send("R8", 8'h90, 8'h69);              // 9 bits, ninth = 0
        send("R3", 8'h18, 8'h81);              // code 11 behaves as 8 bits
        send("R2", 8'h07, 8'h11);              // low write bits dropped

        // R9/R10/R11: back-to-back words, dropped write, control change mid-frame.
        cur_req = "R10";
        wr(1'b0, 8'hA0);
        @(negedge clk); wr_en = 1; wr_sel = 1; wr_data = 8'h5A;
        @(negedge clk); wr_data = 8'hC3;       // buffer full here: ignored
        @(negedge clk); wr_en = 0;
        cur_req = "R9";
        while (!buf_empty) @(negedge clk);
        wr(1'b1, 8'h0F);                       // queued behind the frame in flight
        cur_req = "R11";
        repeat (5) @(negedge clk);
        wr(1'b0, 8'hD0);                       // change settings during the frame
        wait_done();
        cur_req = "R5";
        send("R5", 8'h10, 8'h33);

        // R1: reset in the middle of a frame.
        cur_req = "R1";
        wr(1'b0, 8'h88);
        wr(1'b1, 8'hE7);
        repeat (20) @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        check("R1", "mid-frame reset tx_line", tx_line, 1);
        check("R1", "mid-frame reset buf_empty", buf_empty, 1);
        check("R1", "mid-frame reset status", ctrl_status, 8'h01);
        rst_n = 1;
        send("R4", 8'h00, 8'h01);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule